// File: doc/BRIEF.md
# Bootstrap Load Sequencer

This block runs the bootstrap load of a small processor model. A one-cycle load request carries a 12-bit device address. The sequencer raises a system reset pulse, then moves a fixed-size block of bytes from the chosen device into low memory. That first move acts as if an 8-byte channel command word were already in place. Loading then goes on through chained command words that the sequencer reads from low memory, starting at byte 8.

When the last command in the chain completes, the device address is written as a halfword into low memory. The 64-bit processor status word is then read back from bytes 0 to 7 and presented on an output with a one-cycle strobe. A load light stays on for the whole sequence. If a transfer ends short and no length suppression was requested, an error flag is raised and no status word is produced.

The device interface is a byte-wide read handshake. Memory sits outside the block behind a single byte port: registered writes, and reads with one cycle of latency.

Top module: `boot_load_seq`

## Requirements
- R1: A load request accepted while idle turns `load_light_o` on at once. `sys_reset_o` rises on the next cycle and stays high for exactly RST_CYCLES (default 4) cycles. `dev_rd_o` stays low until the reset pulse has ended.
- R2: The first transfer issues device command 0x02 on `dev_cmd_o` with the requested address on `dev_sel_o`. It writes the received bytes, in order, to memory addresses 0, 1, 2 and so on, up to exactly 24 bytes.
- R3: The first transfer carries both command chaining and length suppression. A device end-of-data (`dev_eod_i`) before 24 bytes is therefore not an error, and loading continues with a command fetch.
- R4: A command word is 8 memory bytes, read with the lowest address as the most significant byte. Its fields are command[63:56], data address[55:32], flags[31:24], an unused byte[23:16] and byte count[15:0]. Flag bit 1 is chaining and flag bit 2 is length suppression. The first fetch reads bytes 8 to 15, and each later fetch reads 8 bytes higher.
- R5: A fetched command moves its count of bytes to its data address, presenting its command byte on `dev_cmd_o`. The chain ends after the first command whose chaining bit is clear.
- R6: When the chain ends, the device address is written as a halfword to memory byte 2 (upper bits, zero-extended) and byte 3 (low 8 bits).
- R7: After the halfword store, bytes 0 to 7 are read with byte 0 as the most significant byte. The result appears on `psw_o` with `psw_valid_o` high for exactly one cycle.
- R8: `load_light_o` goes off on the same edge that raises `psw_valid_o`. The only other thing that turns it off is an error.
- R9: If end-of-data arrives before the count is reached and the current command has length suppression clear, `err_o` is set, the load light goes off and no status word is produced. `err_o` stays set until the next accepted load request.
- R10: A load request that arrives while a load is in progress is ignored. The reset pulse, the device address and the memory traffic of the running load are unchanged.
- R11: A command with a byte count of zero raises no device read and moves straight on.
- R12: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request pulse |
| dev_addr_i | input | 12 | Device address for the load |
| sys_reset_o | output | 1 | System reset pulse |
| load_light_o | output | 1 | High while a load is in progress |
| err_o | output | 1 | Short-transfer error flag |
| dev_rd_o | output | 1 | Byte requested from the device |
| dev_cmd_o | output | 8 | Command byte of the current transfer |
| dev_sel_o | output | 12 | Selected device address |
| dev_valid_i | input | 1 | Device presents a byte |
| dev_data_i | input | 8 | Device byte |
| dev_eod_i | input | 1 | Device has no more data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the read strobe |
| psw_o | output | 64 | Loaded status word |
| psw_valid_o | output | 1 | Status word strobe |

## Verification
The checker watches several timing relations on every cycle: that device reads never overlap the reset pulse, that the reset pulse rises exactly one cycle after the load light, and that the status strobe lasts one cycle and coincides with the light going out. It also checks that an error never comes with a status word and that the memory port never reads and writes at once. The remaining behaviours can only be shown by the bench scenarios: the contents and order of memory writes, the command-word decoding and chain walk, the halfword store, the assembled status word, and the effect of short data with and without length suppression.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_XFER,
    ST_FETCH,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_STATUS
  } seq_state_t;

  // Command word as read from memory, lowest address in the top byte.
  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] data_addr;
    logic [7:0]  flags;
    logic [7:0]  spare;
    logic [15:0] count;
  } cmd_word_t;

endpackage

// File: rtl/boot_reset_pulse.sv
module boot_reset_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (fire_i) begin
        cnt     <= CW'(RST_CYCLES);
        pulse_o <= 1'b1;
      end else if (cnt == CW'(1)) begin
        cnt     <= '0;
        pulse_o <= 1'b0;
        done_o  <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/boot_byte_mover.sv
module boot_byte_mover #(
  parameter int AW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             sli_i,
  output logic             dev_rd_o,
  input  logic             dev_valid_i,
  input  logic [7:0]       dev_data_i,
  input  logic             dev_eod_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic             done_o,
  output logic             short_o
);
  logic             active;
  logic             sli_q;
  logic [CNT_W-1:0] remain;
  logic [AW-1:0]    ptr;

  assign dev_rd_o = active && (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sli_q   <= 1'b0;
      remain  <= '0;
      ptr     <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      we_o    <= 1'b0;
      done_o  <= 1'b0;
      short_o <= 1'b0;
      if (load_i) begin
        active <= 1'b1;
        sli_q  <= sli_i;
        remain <= count_i;
        ptr    <= addr_i;
      end else if (active) begin
        if (remain == '0) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end else if (dev_valid_i) begin
          we_o    <= 1'b1;
          waddr_o <= ptr;
          wdata_o <= dev_data_i;
          ptr     <= ptr + AW'(1);
          remain  <= remain - CNT_W'(1);
        end else if (dev_eod_i) begin
          active <= 1'b0;
          if (sli_q) done_o  <= 1'b1;
          else       short_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/boot_word_reader.sv
module boot_word_reader #(
  parameter int AW     = 16,
  parameter int NBYTES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  output logic                re_o,
  output logic [AW-1:0]       addr_o,
  input  logic [7:0]          rdata_i,
  output logic [NBYTES*8-1:0] word_o,
  output logic                done_o
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam int WW = NBYTES * 8;

  logic          issuing;
  logic          re_q;
  logic [CW-1:0] iss;
  logic [CW-1:0] cap;
  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing <= 1'b0;
      re_q    <= 1'b0;
      iss     <= '0;
      cap     <= '0;
      base    <= '0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      word_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      re_q   <= re_o;
      if (start_i) begin
        issuing <= 1'b1;
        iss     <= '0;
        base    <= base_i;
        re_o    <= 1'b0;
      end else if (issuing) begin
        re_o   <= 1'b1;
        addr_o <= base + AW'(iss);
        iss    <= iss + CW'(1);
        if (iss == CW'(NBYTES - 1)) issuing <= 1'b0;
      end else begin
        re_o <= 1'b0;
      end
      if (re_q) begin
        word_o <= {word_o[WW-9:0], rdata_i};
        if (cap == CW'(NBYTES - 1)) begin
          cap    <= '0;
          done_o <= 1'b1;
        end else begin
          cap <= cap + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/boot_load_seq.sv
module boot_load_seq
  import boot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DEV_AW     = 12,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 4,
  parameter int INIT_COUNT = 24,
  parameter int CCW_START  = 8,
  parameter int CCW_BYTES  = 8,
  parameter int ADDR_SLOT  = 2,
  parameter int CHAIN_BIT  = 1,
  parameter int SLI_BIT    = 2,
  parameter logic [7:0] IPL_CMD = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DEV_AW-1:0] dev_addr_i,
  output logic              sys_reset_o,
  output logic              load_light_o,
  output logic              err_o,
  output logic              dev_rd_o,
  output logic [7:0]        dev_cmd_o,
  output logic [DEV_AW-1:0] dev_sel_o,
  input  logic              dev_valid_i,
  input  logic [7:0]        dev_data_i,
  input  logic              dev_eod_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [63:0]       psw_o,
  output logic              psw_valid_o
);
  localparam int WORD_W = CCW_BYTES * 8;
  localparam logic [15:0] ZERO_HALF = '0;

  seq_state_t        state;
  logic              rg_fire, rg_done;
  logic              xf_load, xf_sli, xf_we, xf_done, xf_short;
  logic [AW-1:0]     xf_addr, xf_waddr;
  logic [CNT_W-1:0]  xf_count;
  logic [7:0]        xf_wdata;
  logic              rd_start, rd_re, rd_done;
  logic [AW-1:0]     rd_base, rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              st_we;
  logic [AW-1:0]     st_addr;
  logic [7:0]        st_data;
  logic [AW-1:0]     ccw_ptr;
  logic [DEV_AW-1:0] dev_q;
  logic [7:0]        cmd_q;
  logic              chain_q;
  logic [15:0]       half;
  cmd_word_t         cw;

  assign half = ZERO_HALF | 16'(dev_q);
  assign cw   = cmd_word_t'(rd_word);

  boot_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .fire_i(rg_fire),
    .pulse_o(sys_reset_o), .done_o(rg_done)
  );

  boot_byte_mover #(.AW(AW), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst(rst), .load_i(xf_load), .addr_i(xf_addr),
    .count_i(xf_count), .sli_i(xf_sli), .dev_rd_o(dev_rd_o),
    .dev_valid_i(dev_valid_i), .dev_data_i(dev_data_i), .dev_eod_i(dev_eod_i),
    .we_o(xf_we), .waddr_o(xf_waddr), .wdata_o(xf_wdata),
    .done_o(xf_done), .short_o(xf_short)
  );

  boot_word_reader #(.AW(AW), .NBYTES(CCW_BYTES)) u_reader (
    .clk(clk), .rst(rst), .start_i(rd_start), .base_i(rd_base),
    .re_o(rd_re), .addr_o(rd_addr), .rdata_i(mem_rdata_i),
    .word_o(rd_word), .done_o(rd_done)
  );

  // Memory port: the three sources are active in disjoint phases.
  assign mem_we_o    = xf_we | st_we;
  assign mem_re_o    = rd_re;
  assign mem_addr_o  = rd_re ? rd_addr : (st_we ? st_addr : xf_waddr);
  assign mem_wdata_o = st_we ? st_data : xf_wdata;
  assign dev_cmd_o   = cmd_q;
  assign dev_sel_o   = dev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      load_light_o <= 1'b0;
      err_o        <= 1'b0;
      psw_o        <= '0;
      psw_valid_o  <= 1'b0;
      rg_fire      <= 1'b0;
      xf_load      <= 1'b0;
      xf_addr      <= '0;
      xf_count     <= '0;
      xf_sli       <= 1'b0;
      rd_start     <= 1'b0;
      rd_base      <= '0;
      st_we        <= 1'b0;
      st_addr      <= '0;
      st_data      <= '0;
      ccw_ptr      <= '0;
      dev_q        <= '0;
      cmd_q        <= '0;
      chain_q      <= 1'b0;
    end else begin
      rg_fire     <= 1'b0;
      xf_load     <= 1'b0;
      rd_start    <= 1'b0;
      st_we       <= 1'b0;
      psw_valid_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            dev_q        <= dev_addr_i;
            load_light_o <= 1'b1;
            err_o        <= 1'b0;
            rg_fire      <= 1'b1;
            state        <= ST_RESET;
          end
        end
        ST_RESET: begin
          if (rg_done) begin
            xf_load  <= 1'b1;
            xf_addr  <= '0;
            xf_count <= CNT_W'(INIT_COUNT);
            xf_sli   <= 1'b1;
            chain_q  <= 1'b1;
            cmd_q    <= IPL_CMD;
            ccw_ptr  <= AW'(CCW_START);
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xf_short) begin
            err_o        <= 1'b1;
            load_light_o <= 1'b0;
            state        <= ST_IDLE;
          end else if (xf_done) begin
            if (chain_q) begin
              rd_start <= 1'b1;
              rd_base  <= ccw_ptr;
              state    <= ST_FETCH;
            end else begin
              st_we   <= 1'b1;
              st_addr <= AW'(ADDR_SLOT);
              st_data <= half[15:8];
              state   <= ST_ADDR_HI;
            end
          end
        end
        ST_FETCH: begin
          if (rd_done) begin
            cmd_q    <= cw.op;
            chain_q  <= cw.flags[CHAIN_BIT];
            xf_load  <= 1'b1;
            xf_addr  <= cw.data_addr[AW-1:0];
            xf_count <= CNT_W'(cw.count);
            xf_sli   <= cw.flags[SLI_BIT];
            ccw_ptr  <= ccw_ptr + AW'(CCW_BYTES);
            state    <= ST_XFER;
          end
        end
        ST_ADDR_HI: begin
          st_we   <= 1'b1;
          st_addr <= AW'(ADDR_SLOT + 1);
          st_data <= half[7:0];
          state   <= ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          rd_start <= 1'b1;
          rd_base  <= '0;
          state    <= ST_STATUS;
        end
        ST_STATUS: begin
          if (rd_done) begin
            psw_o        <= 64'(rd_word);
            psw_valid_o  <= 1'b1;
            load_light_o <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_load_seq_chk.sv
module boot_load_seq_chk (
  input logic clk,
  input logic rst,
  input logic sys_reset_o,
  input logic load_light_o,
  input logic err_o,
  input logic dev_rd_o,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic psw_valid_o
);
  a_r1_no_read_in_reset: assert property (@(posedge clk) disable iff (rst)
    dev_rd_o |-> !sys_reset_o);

  a_r1_reset_after_light: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_reset_o) |-> $past(load_light_o) && !$past(load_light_o, 2));

  a_r1_read_needs_light: assert property (@(posedge clk) disable iff (rst)
    dev_rd_o |-> load_light_o);

  a_r7_status_one_cycle: assert property (@(posedge clk) disable iff (rst)
    psw_valid_o |=> !psw_valid_o);

  a_r8_light_off_with_status: assert property (@(posedge clk) disable iff (rst)
    psw_valid_o |-> !load_light_o && $past(load_light_o));

  a_r8_light_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(load_light_o) |-> (psw_valid_o || err_o));

  a_r9_no_status_on_error: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !psw_valid_o);

  a_r12_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));
endmodule

bind boot_load_seq boot_load_seq_chk chk_i (
  .clk(clk), .rst(rst), .sys_reset_o(sys_reset_o), .load_light_o(load_light_o),
  .err_o(err_o), .dev_rd_o(dev_rd_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
  .psw_valid_o(psw_valid_o)
);

// File: tb/boot_load_seq_tb_top.sv
module boot_load_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [11:0] dev_addr_i = '0;
  logic        sys_reset_o, load_light_o, err_o, dev_rd_o;
  logic [7:0]  dev_cmd_o;
  logic [11:0] dev_sel_o;
  logic        dev_valid_i = 1'b0;
  logic [7:0]  dev_data_i = '0;
  logic        dev_eod_i = 1'b0;
  logic        mem_we_o, mem_re_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [63:0] psw_o;
  logic        psw_valid_o;

  always #10 clk = ~clk;

  boot_load_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .sys_reset_o(sys_reset_o), .load_light_o(load_light_o), .err_o(err_o),
    .dev_rd_o(dev_rd_o), .dev_cmd_o(dev_cmd_o), .dev_sel_o(dev_sel_o),
    .dev_valid_i(dev_valid_i), .dev_data_i(dev_data_i), .dev_eod_i(dev_eod_i),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .psw_o(psw_o), .psw_valid_o(psw_valid_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rst_cycles = 0;
  int overlap = 0;
  int psw_cnt = 0;
  int consumed = 0;
  int gap_ctr = 0;
  logic prev_light = 1'b0;
  logic [11:0] exp_sel = '0;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [8:0]  dev_q [$];
  logic [23:0] exp_q [$];
  string       exp_tag [$];
  logic [7:0]  cmd_log [$];

  task automatic check(input string req, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_write(input string req, input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    exp_tag.push_back(req);
    exp_mem[a[7:0]] = d;
  endtask

  function automatic logic [63:0] exp_psw();
    logic [63:0] w = '0;
    for (int i = 0; i < 8; i++) w = {w[55:0], exp_mem[i]};
    return w;
  endfunction

  // Memory model: registered write, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  // Device model and scoreboard monitor, both away from the active edge.
  always @(negedge clk) begin
    dev_valid_i <= 1'b0;
    dev_eod_i   <= 1'b0;
    gap_ctr++;
    if (dev_rd_o && (gap_ctr % 7 != 3)) begin
      if (dev_q.size() == 0 || dev_q[0][8]) begin
        if (dev_q.size() != 0) void'(dev_q.pop_front());
        dev_eod_i <= 1'b1;
      end else begin
        dev_data_i  <= dev_q.pop_front()[7:0];
        dev_valid_i <= 1'b1;
        consumed++;
        cmd_log.push_back(dev_cmd_o);
        if (dev_sel_o != exp_sel) check("R10 device select", 1'b0, 64'(dev_sel_o), 64'(exp_sel));
      end
    end
    if (sys_reset_o) rst_cycles++;
    if (sys_reset_o && dev_rd_o) overlap++;
    if (mem_we_o) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected write", 1'b0, 64'({mem_addr_o, mem_wdata_o}), 64'(0));
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(t, {mem_addr_o, mem_wdata_o} == e, 64'({mem_addr_o, mem_wdata_o}), 64'(e));
      end
    end
    if (psw_valid_o) begin
      psw_cnt++;
      check("R7 status word", psw_o == exp_psw(), psw_o, exp_psw());
      check("R8 light off with strobe", !load_light_o && prev_light,
            64'({load_light_o, prev_light}), 64'(2'b01));
    end
    prev_light <= load_light_o;
  end

  task automatic pulse_start(input logic [11:0] a);
    @(negedge clk);
    dev_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(input int base_psw);
    int n = 0;
    while (psw_cnt == base_psw && !err_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic push_bytes(input logic [7:0] b []);
    foreach (b[i]) dev_q.push_back({1'b0, b[i]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1'b0, 64'(0), 64'(1));
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] img [];
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {load_light_o, err_o, sys_reset_o, dev_rd_o, psw_valid_o} == 5'b0,
          64'({load_light_o, err_o, sys_reset_o, dev_rd_o, psw_valid_o}), 64'(0));

    // Scenario A: two chained commands, second one short with suppression set.
    img = new[24];
    for (int i = 0; i < 8; i++) img[i] = 8'hA0 + 8'(i);
    img[8]  = 8'h06; img[9]  = 8'h00; img[10] = 8'h00; img[11] = 8'h40;
    img[12] = 8'h02; img[13] = 8'h00; img[14] = 8'h00; img[15] = 8'h04;
    img[16] = 8'h02; img[17] = 8'h00; img[18] = 8'h00; img[19] = 8'h50;
    img[20] = 8'h04; img[21] = 8'h00; img[22] = 8'h00; img[23] = 8'h06;
    push_bytes(img);
    push_bytes('{8'hC0, 8'hC1, 8'hC2, 8'hC3});
    push_bytes('{8'hD0, 8'hD1, 8'hD2});
    dev_q.push_back(9'h100);
    for (int i = 0; i < 24; i++) expect_write("R2 initial bytes", 16'(i), img[i]);
    for (int i = 0; i < 4; i++) expect_write("R4 first chained data", 16'h40 + 16'(i), 8'hC0 + 8'(i));
    for (int i = 0; i < 3; i++) expect_write("R5 short suppressed data", 16'h50 + 16'(i), 8'hD0 + 8'(i));
    expect_write("R6 address high byte", 16'd2, 8'h05);
    expect_write("R6 address low byte", 16'd3, 8'hA3);
    exp_sel = 12'h5A3; rst_cycles = 0; overlap = 0; consumed = 0; cmd_log.delete();
    p0 = psw_cnt;
    pulse_start(12'h5A3);
    repeat (30) @(negedge clk);
    pulse_start(12'h111);
    wait_end(p0);
    check("R1 reset pulse length", rst_cycles == 4, 64'(rst_cycles), 64'(4));
    check("R1 no read during reset", overlap == 0, 64'(overlap), 64'(0));
    check("R10 one reset for two requests", rst_cycles == 4, 64'(rst_cycles), 64'(4));
    check("R2 initial command byte", cmd_log.size() > 24 && cmd_log[0] == 8'h02,
          64'(cmd_log[0]), 64'h02);
    check("R5 fetched command byte", cmd_log.size() > 24 && cmd_log[24] == 8'h06,
          64'(cmd_log[24]), 64'h06);
    check("R5 chain ends, all writes seen", exp_q.size() == 0, 64'(exp_q.size()), 64'(0));
    check("R7 one status strobe", psw_cnt == p0 + 1, 64'(psw_cnt), 64'(p0 + 1));
    check("R3 suppressed short not error", !err_o, 64'(err_o), 64'(0));

    // Scenario B: chained command with suppression clear ends short.
    dev_q.delete();
    img = new[24];
    for (int i = 0; i < 24; i++) img[i] = 8'hB0 + 8'(i);
    img[8]  = 8'h02; img[9]  = 8'h00; img[10] = 8'h00; img[11] = 8'h60;
    img[12] = 8'h00; img[13] = 8'h00; img[14] = 8'h00; img[15] = 8'h05;
    push_bytes(img);
    push_bytes('{8'hE0, 8'hE1});
    dev_q.push_back(9'h100);
    for (int i = 0; i < 24; i++) expect_write("R2 initial bytes", 16'(i), img[i]);
    for (int i = 0; i < 2; i++) expect_write("R9 bytes before short end", 16'h60 + 16'(i), 8'hE0 + 8'(i));
    exp_sel = 12'h0C7; p0 = psw_cnt;
    pulse_start(12'h0C7);
    wait_end(p0);
    repeat (20) @(negedge clk);
    check("R9 error flag", err_o == 1'b1, 64'(err_o), 64'(1));
    check("R9 light off on error", !load_light_o, 64'(load_light_o), 64'(0));
    check("R9 no status word", psw_cnt == p0, 64'(psw_cnt), 64'(p0));
    check("R9 no address store", exp_q.size() == 0, 64'(exp_q.size()), 64'(0));

    // Scenario C: initial read short (built-in suppression), zero-count command.
    dev_q.delete();
    img = new[16];
    for (int i = 0; i < 8; i++) img[i] = 8'hC0 + 8'(i);
    img[8]  = 8'h03; img[9]  = 8'h00; img[10] = 8'h00; img[11] = 8'h70;
    img[12] = 8'h00; img[13] = 8'h00; img[14] = 8'h00; img[15] = 8'h00;
    push_bytes(img);
    dev_q.push_back(9'h100);
    push_bytes('{8'hFE, 8'hFD});
    for (int i = 0; i < 16; i++) expect_write("R3 short initial bytes", 16'(i), img[i]);
    expect_write("R6 address high byte", 16'd2, 8'h0F);
    expect_write("R6 address low byte", 16'd3, 8'hFF);
    exp_sel = 12'hFFF; p0 = psw_cnt; consumed = 0;
    pulse_start(12'hFFF);
    repeat (2) @(negedge clk);
    check("R9 error cleared by new load", !err_o, 64'(err_o), 64'(0));
    wait_end(p0);
    check("R3 loading continued", psw_cnt == p0 + 1 && !err_o, 64'(psw_cnt), 64'(p0 + 1));
    check("R11 zero count reads nothing", consumed == 16, 64'(consumed), 64'(16));
    check("R6 all writes seen", exp_q.size() == 0, 64'(exp_q.size()), 64'(0));
    check("R8 light off after load", !load_light_o, 64'(load_light_o), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule